// File: doc/BRIEF.md
# Configurable Row Match Processor

This block compares one row of stored records against a search key and reports which records match. It is meant to sit behind a hashed row memory: the memory delivers a whole row of records in one cycle, and this block decides which of them agree with the key and returns the winning record's payload in the same result. Each record carries a valid bit, a key, a per-bit mask, a pair of range bounds and a data word.

The comparison is shaped at run time by configuration inputs. A bit-select mask sets which key bits take part, and so sets the effective key width. A ternary-enable mask picks, for each bit position, whether the stored mask bit may turn that position into a wildcard. An optional range check extracts a field from the search key, at a chosen offset and length, and requires it to lie between the record's bounds.

Results are registered. One cycle after a search is presented, the block shows the per-record match vector, a hit flag, the index of the lowest-numbered matching record and that record's data word.

Top module: `tmatch_row`

## Requirements
- R1: A key bit whose `cfg_bit_sel` bit is 0 never causes a mismatch; with `cfg_bit_sel` all zero and the range check off, every valid record matches.
- R2: At a selected bit position whose `cfg_tern_en` bit is 1, a record whose mask bit there is 1 matches either search value; with mask bit 0 it needs equality.
- R3: At a selected bit position whose `cfg_tern_en` bit is 0, the record's mask bit has no effect and the stored bit must equal the search bit; binary and ternary positions mix freely within one key.
- R4: With `cfg_rng_en` at 1, the range field is search-key bits starting at `cfg_rng_off`, taking min(`cfg_rng_len`, RANGE_W) bits, zero-extended (bits past the key's top read as 0); a record matches only if low ≤ field ≤ high, unsigned and inclusive, so low > high never matches. With `cfg_rng_en` at 0 the bounds have no effect.
- R5: `hit_data` is the data word of the record named by `hit_idx`, delivered in the same cycle as the match vector.
- R6: `hit` is 1 exactly when any bit of `match_vec` is 1, and `hit_idx` is the lowest index whose `match_vec` bit is 1.
- R7: A record whose `row_valid` bit is 0 never matches.
- R8: A search sampled with `in_valid` at 1 on a rising edge appears at the outputs right after that edge, with `out_valid` at 1.
- R9: When there is no hit, `hit_idx` and `hit_data` are 0; after an edge with `in_valid` at 0, `out_valid`, `match_vec` and `hit` are 0.
- R10: While `rst_n` is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A search is presented this cycle |
| search_key | input | KEY_W | Search key |
| row_valid | input | N_ENTRIES | Per-record valid bits |
| row_key | input | N_ENTRIES*KEY_W | Stored keys, record 0 in the low bits |
| row_mask | input | N_ENTRIES*KEY_W | Stored wildcard masks, 1 = don't care |
| row_lo | input | N_ENTRIES*RANGE_W | Range low bounds |
| row_hi | input | N_ENTRIES*RANGE_W | Range high bounds |
| row_data | input | N_ENTRIES*DATA_W | Stored data words |
| cfg_bit_sel | input | KEY_W | 1 = key bit takes part in the compare |
| cfg_tern_en | input | KEY_W | 1 = ternary compare at this bit |
| cfg_rng_en | input | 1 | Enable the range check |
| cfg_rng_off | input | OFF_W | Lowest search-key bit of the range field |
| cfg_rng_len | input | LEN_W | Range field length in bits |
| out_valid | output | 1 | Result valid |
| match_vec | output | N_ENTRIES | Per-record match flags |
| hit | output | 1 | At least one record matched |
| hit_idx | output | IDX_W | Index of the first matching record |
| hit_data | output | DATA_W | Data word of the first matching record |

## Verification
A fault in one record's comparator shows as a single wrong bit of `match_vec` one cycle after the search, and, when that record is the lowest match, as a wrong `hit_idx` and `hit_data` in the same cycle. Errors in the range field extraction show only for keys whose bits at the chosen offset cross a bound, so whole-key sweeps with bounds placed at 0, at the field maximum, on a single point and inverted bring them out. A fault in the priority choice shows only when two or more records match, which a sweep over every valid-bit pattern of identical records exposes on the first affected search.

// File: rtl/tm_pkg.sv
package tm_pkg;

   // One key bit agrees with the search bit under the current configuration.
   function automatic logic bit_agrees(input logic stored, input logic probe,
                                       input logic sel, input logic tern,
                                       input logic wild);
      return !sel || (tern && wild) || (stored == probe);
   endfunction

   // Number of bits needed to hold values 0..v.
   function automatic int unsigned bits_for(input int unsigned v);
      int unsigned n;
      n = 1;
      while ((1 << n) <= v) n++;
      return n;
   endfunction

endpackage

// File: rtl/tm_range_field.sv
module tm_range_field #(
   parameter int KEY_W   = 16,
   parameter int RANGE_W = 8,
   parameter int OFF_W   = 4,
   parameter int LEN_W   = 4
) (
   input  logic [KEY_W-1:0]   search_key,
   input  logic [OFF_W-1:0]   off,
   input  logic [LEN_W-1:0]   len,
   output logic [RANGE_W-1:0] field
);
   logic [KEY_W-1:0] shifted;

   always_comb begin
      shifted = search_key >> off;
      for (int i = 0; i < RANGE_W; i++) begin
         field[i] = (i < int'(len)) ? shifted[i] : 1'b0;
      end
   end
endmodule

// File: rtl/tm_entry_cmp.sv
module tm_entry_cmp
   import tm_pkg::*;
#(
   parameter int KEY_W    = 16,
   parameter int RANGE_W  = 8,
   parameter bit RANGE_ON = 1'b1
) (
   input  logic               valid,
   input  logic [KEY_W-1:0]   key,
   input  logic [KEY_W-1:0]   wild,
   input  logic [RANGE_W-1:0] lo,
   input  logic [RANGE_W-1:0] hi,
   input  logic [KEY_W-1:0]   search_key,
   input  logic [RANGE_W-1:0] field,
   input  logic [KEY_W-1:0]   bit_sel,
   input  logic [KEY_W-1:0]   tern_en,
   input  logic               rng_en,
   output logic               match
);
   logic [KEY_W-1:0] agree;
   logic             in_range;

   genvar b;
   generate
      for (b = 0; b < KEY_W; b++) begin : g_bit
         assign agree[b] = bit_agrees(key[b], search_key[b], bit_sel[b],
                                      tern_en[b], wild[b]);
      end

      if (RANGE_ON) begin : g_rng
         assign in_range = !rng_en || ((field >= lo) && (field <= hi));
      end else begin : g_no_rng
         assign in_range = 1'b1;
      end
   endgenerate

   assign match = valid && (&agree) && in_range;
endmodule

// File: rtl/tm_first_hit.sv
module tm_first_hit #(
   parameter int N_ENTRIES = 8,
   parameter int DATA_W    = 8,
   parameter int IDX_W     = 3
) (
   input  logic [N_ENTRIES-1:0]        match_vec,
   input  logic [N_ENTRIES*DATA_W-1:0] data_flat,
   output logic                        any,
   output logic [IDX_W-1:0]            idx,
   output logic [DATA_W-1:0]           data
);
   always_comb begin
      any  = 1'b0;
      idx  = '0;
      data = '0;
      for (int i = N_ENTRIES - 1; i >= 0; i--) begin
         if (match_vec[i]) begin
            any  = 1'b1;
            idx  = IDX_W'(i);
            data = data_flat[i*DATA_W +: DATA_W];
         end
      end
   end
endmodule

// File: rtl/tmatch_row.sv
module tmatch_row
   import tm_pkg::*;
#(
   parameter int N_ENTRIES = 8,
   parameter int KEY_W     = 16,
   parameter int RANGE_W   = 8,
   parameter int DATA_W    = 8,
   parameter bit RANGE_ON  = 1'b1,
   localparam int IDX_W    = $clog2(N_ENTRIES),
   localparam int OFF_W    = $clog2(KEY_W),
   localparam int LEN_W    = bits_for(RANGE_W)
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           in_valid,
   input  logic [KEY_W-1:0]               search_key,
   input  logic [N_ENTRIES-1:0]           row_valid,
   input  logic [N_ENTRIES*KEY_W-1:0]     row_key,
   input  logic [N_ENTRIES*KEY_W-1:0]     row_mask,
   input  logic [N_ENTRIES*RANGE_W-1:0]   row_lo,
   input  logic [N_ENTRIES*RANGE_W-1:0]   row_hi,
   input  logic [N_ENTRIES*DATA_W-1:0]    row_data,
   input  logic [KEY_W-1:0]               cfg_bit_sel,
   input  logic [KEY_W-1:0]               cfg_tern_en,
   input  logic                           cfg_rng_en,
   input  logic [OFF_W-1:0]               cfg_rng_off,
   input  logic [LEN_W-1:0]               cfg_rng_len,
   output logic                           out_valid,
   output logic [N_ENTRIES-1:0]           match_vec,
   output logic                           hit,
   output logic [IDX_W-1:0]               hit_idx,
   output logic [DATA_W-1:0]              hit_data
);
   generate
      if (N_ENTRIES < 2) begin : g_bad_n
         $error("tmatch_row: N_ENTRIES must be at least 2");
      end
      if (KEY_W < 2) begin : g_bad_key
         $error("tmatch_row: KEY_W must be at least 2");
      end
      if (RANGE_W < 1 || RANGE_W > KEY_W) begin : g_bad_rng
         $error("tmatch_row: RANGE_W must lie in 1..KEY_W");
      end
      if (DATA_W < 1) begin : g_bad_data
         $error("tmatch_row: DATA_W must be at least 1");
      end
   endgenerate

   logic [RANGE_W-1:0]   field;
   logic [N_ENTRIES-1:0] mv_c;
   logic                 any_c;
   logic [IDX_W-1:0]     idx_c;
   logic [DATA_W-1:0]    data_c;

   generate
      if (RANGE_ON) begin : g_field
         tm_range_field #(
            .KEY_W  (KEY_W),
            .RANGE_W(RANGE_W),
            .OFF_W  (OFF_W),
            .LEN_W  (LEN_W)
         ) u_field (
            .search_key(search_key),
            .off       (cfg_rng_off),
            .len       (cfg_rng_len),
            .field     (field)
         );
      end else begin : g_no_field
         assign field = '0;
      end
   endgenerate

   genvar e;
   generate
      for (e = 0; e < N_ENTRIES; e++) begin : g_ent
         tm_entry_cmp #(
            .KEY_W   (KEY_W),
            .RANGE_W (RANGE_W),
            .RANGE_ON(RANGE_ON)
         ) u_cmp (
            .valid     (row_valid[e]),
            .key       (row_key[e*KEY_W +: KEY_W]),
            .wild      (row_mask[e*KEY_W +: KEY_W]),
            .lo        (row_lo[e*RANGE_W +: RANGE_W]),
            .hi        (row_hi[e*RANGE_W +: RANGE_W]),
            .search_key(search_key),
            .field     (field),
            .bit_sel   (cfg_bit_sel),
            .tern_en   (cfg_tern_en),
            .rng_en    (cfg_rng_en),
            .match     (mv_c[e])
         );
      end
   endgenerate

   tm_first_hit #(
      .N_ENTRIES(N_ENTRIES),
      .DATA_W   (DATA_W),
      .IDX_W    (IDX_W)
   ) u_first (
      .match_vec(mv_c),
      .data_flat(row_data),
      .any      (any_c),
      .idx      (idx_c),
      .data     (data_c)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         match_vec <= '0;
         hit       <= 1'b0;
         hit_idx   <= '0;
         hit_data  <= '0;
      end else begin
         out_valid <= in_valid;
         match_vec <= in_valid ? mv_c : '0;
         hit       <= in_valid && any_c;
         hit_idx   <= in_valid ? idx_c : '0;
         hit_data  <= in_valid ? data_c : '0;
      end
   end
endmodule

// File: rtl/tmatch_row_chk.sv
module tmatch_row_chk #(
   parameter int N_ENTRIES = 8,
   parameter int DATA_W    = 8,
   parameter int IDX_W     = 3
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic                        in_valid,
   input logic [N_ENTRIES-1:0]        row_valid,
   input logic [N_ENTRIES*DATA_W-1:0] row_data,
   input logic                        out_valid,
   input logic [N_ENTRIES-1:0]        match_vec,
   input logic                        hit,
   input logic [IDX_W-1:0]            hit_idx,
   input logic [DATA_W-1:0]           hit_data
);
   logic [N_ENTRIES*DATA_W-1:0] data_q;
   logic [N_ENTRIES-1:0]        below;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) data_q <= '0;
      else        data_q <= row_data;
   end

   always_comb begin
      below = '0;
      for (int i = 0; i < N_ENTRIES; i++) begin
         if (i < int'(hit_idx)) below[i] = 1'b1;
      end
   end

   // R8
   result_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   // R9
   idle_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!out_valid && !hit && (match_vec == '0)));

   // R6
   hit_any_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit == (|match_vec));

   // R6
   first_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> (match_vec[hit_idx] && ((match_vec & below) == '0)));

   // R7
   invalid_excluded_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> ((match_vec & ~$past(row_valid)) == '0));

   // R5
   data_of_winner_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> (hit_data == data_q[hit_idx*DATA_W +: DATA_W]));

   // R9
   miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !hit |-> ((hit_idx == '0) && (hit_data == '0)));
endmodule

bind tmatch_row tmatch_row_chk #(
   .N_ENTRIES(N_ENTRIES),
   .DATA_W   (DATA_W),
   .IDX_W    (IDX_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .in_valid (in_valid),
   .row_valid(row_valid),
   .row_data (row_data),
   .out_valid(out_valid),
   .match_vec(match_vec),
   .hit      (hit),
   .hit_idx  (hit_idx),
   .hit_data (hit_data)
);

// File: tb/tb_tmatch_row.sv
`timescale 1ns/1ps
module tb_tmatch_row;
   localparam int N  = 4;
   localparam int KW = 8;
   localparam int RW = 4;
   localparam int DW = 8;
   localparam int IW = 2;
   localparam int OW = 3;
   localparam int LW = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic            in_valid = 1'b0;
   logic [KW-1:0]   skey = '0;
   logic [N-1:0]    rvalid = '0;
   logic [KW-1:0]   rkey [N];
   logic [KW-1:0]   rmask[N];
   logic [RW-1:0]   rlo  [N];
   logic [RW-1:0]   rhi  [N];
   logic [DW-1:0]   rdata[N];
   logic [KW-1:0]   sel = '0, tern = '0;
   logic            rng_en = 1'b0;
   logic [OW-1:0]   rng_off = '0;
   logic [LW-1:0]   rng_len = '0;

   logic [N*KW-1:0] f_key, f_mask;
   logic [N*RW-1:0] f_lo, f_hi;
   logic [N*DW-1:0] f_data;

   always_comb begin
      for (int e = 0; e < N; e++) begin
         f_key [e*KW +: KW] = rkey[e];
         f_mask[e*KW +: KW] = rmask[e];
         f_lo  [e*RW +: RW] = rlo[e];
         f_hi  [e*RW +: RW] = rhi[e];
         f_data[e*DW +: DW] = rdata[e];
      end
   end

   logic          out_valid, hit;
   logic [N-1:0]  match_vec;
   logic [IW-1:0] hit_idx;
   logic [DW-1:0] hit_data;

   tmatch_row #(.N_ENTRIES(N), .KEY_W(KW), .RANGE_W(RW), .DATA_W(DW)) dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .search_key(skey),
      .row_valid(rvalid), .row_key(f_key), .row_mask(f_mask),
      .row_lo(f_lo), .row_hi(f_hi), .row_data(f_data),
      .cfg_bit_sel(sel), .cfg_tern_en(tern), .cfg_rng_en(rng_en),
      .cfg_rng_off(rng_off), .cfg_rng_len(rng_len),
      .out_valid(out_valid), .match_vec(match_vec), .hit(hit),
      .hit_idx(hit_idx), .hit_data(hit_data)
   );

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // Expected result from the requirements.
   task automatic expect_of(output logic [N-1:0] mv, output logic h,
                            output logic [IW-1:0] ix, output logic [DW-1:0] d);
      int len, fld;
      mv = '0; h = 1'b0; ix = '0; d = '0;
      len = (int'(rng_len) > RW) ? RW : int'(rng_len);
      fld = (int'(skey) >> int'(rng_off)) & ((1 << len) - 1);
      for (int e = 0; e < N; e++) begin
         bit ok;
         ok = rvalid[e];
         for (int b = 0; b < KW; b++)
            if (sel[b] && !(tern[b] && rmask[e][b]) && (rkey[e][b] != skey[b])) ok = 0;
         if (rng_en && ((fld < int'(rlo[e])) || (fld > int'(rhi[e])))) ok = 0;
         mv[e] = ok;
      end
      for (int e = N - 1; e >= 0; e--)
         if (mv[e]) begin h = 1'b1; ix = IW'(e); d = rdata[e]; end
   endtask

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h (key=%h sel=%h tern=%h rng=%0d off=%0d len=%0d valid=%b)",
                  req, act, exp, skey, sel, tern, rng_en, rng_off, rng_len, rvalid);
      end
   endtask

   // Present the current inputs for one cycle and compare after the edge.
   task automatic search(input string req);
      logic [N-1:0] mv; logic h; logic [IW-1:0] ix; logic [DW-1:0] d;
      expect_of(mv, h, ix, d);
      in_valid = 1'b1;
      @(negedge clk);
      check({req, " R8 R5 R6"}, {out_valid, match_vec, hit, hit_idx, hit_data},
            {1'b1, mv, h, ix, d});
   endtask

   task automatic randomize_row();
      for (int e = 0; e < N; e++) begin
         rkey[e]  = KW'($urandom);
         rmask[e] = KW'($urandom);
         rlo[e]   = RW'($urandom);
         rhi[e]   = RW'($urandom);
         rdata[e] = DW'($urandom) | 8'h01;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      for (int e = 0; e < N; e++) begin
         rkey[e] = '0; rmask[e] = '0; rlo[e] = '0; rhi[e] = '0; rdata[e] = '0;
      end
      repeat (3) @(negedge clk);
      // R10: reset state
      check("R10 reset", {out_valid, match_vec, hit, hit_idx, hit_data}, '0);
      rst_n = 1'b1;
      @(negedge clk);

      // R3: full binary compare, then R1 narrowed selects
      randomize_row();
      rkey[1] = 8'h5A; rkey[3] = 8'h5A; rvalid = 4'b1111;
      sel = 8'hFF; tern = 8'h00;
      for (int k = 0; k < 256; k++) begin skey = KW'(k); search("R3 binary"); end
      sel = 8'h0F;
      for (int k = 0; k < 256; k++) begin skey = KW'(k); search("R1 low nibble"); end
      sel = 8'hA5;
      for (int k = 0; k < 256; k++) begin skey = KW'(k); search("R1 sparse"); end
      sel = 8'h00; skey = 8'h33;
      search("R1 no bits selected");

      // R2 with R3 mixed positions
      randomize_row();
      sel = 8'hFF; tern = 8'hF0;
      for (int k = 0; k < 256; k++) begin skey = KW'(k); search("R2 R3 mixed"); end
      tern = 8'hFF; rmask[0] = 8'hFF;
      for (int k = 0; k < 256; k += 7) begin skey = KW'(k); search("R2 all wild"); end

      // R4 range check, bounds at edges, single point and inverted
      sel = 8'h00; tern = 8'h00; rng_en = 1'b1;
      rlo[0] = 4'd0;  rhi[0] = 4'd15;
      rlo[1] = 4'd3;  rhi[1] = 4'd7;
      rlo[2] = 4'd9;  rhi[2] = 4'd9;
      rlo[3] = 4'd12; rhi[3] = 4'd5;
      rng_off = 3'd2; rng_len = 3'd4;
      for (int k = 0; k < 256; k++) begin skey = KW'(k); search("R4 off2 len4"); end
      rng_off = 3'd6; rng_len = 3'd4;
      for (int k = 0; k < 256; k++) begin skey = KW'(k); search("R4 past key top"); end
      rng_off = 3'd1; rng_len = 3'd7;
      for (int k = 0; k < 256; k++) begin skey = KW'(k); search("R4 len capped"); end
      rng_off = 3'd0; rng_len = 3'd0; rlo[0] = 4'd1;
      skey = 8'hFF; search("R4 zero-length field");
      rng_en = 1'b0; rlo[0] = 4'd9; rhi[0] = 4'd2;
      skey = 8'h44; search("R4 bounds ignored when off");

      // R6 priority and R7 invalid exclusion over every valid pattern
      for (int e = 0; e < N; e++) rdata[e] = DW'(8'hA0 + e);
      sel = 8'h00;
      for (int v = 0; v < 16; v++) begin rvalid = N'(v); search("R6 R7 valid pattern"); end

      // R9: idle cycle clears result
      in_valid = 1'b0;
      @(negedge clk);
      check("R9 idle", {out_valid, match_vec, hit, hit_idx, hit_data}, '0);
      rvalid = 4'b1111; sel = 8'hFF; skey = 8'h00;
      for (int e = 0; e < N; e++) rkey[e] = 8'hFF;
      search("R9 miss gives zero index and data");

      // Random mixed configurations
      for (int t = 0; t < 600; t++) begin
         randomize_row();
         rvalid  = N'($urandom);
         sel     = KW'($urandom);
         tern    = KW'($urandom);
         rng_en  = 1'($urandom);
         rng_off = OW'($urandom);
         rng_len = LW'($urandom);
         skey    = KW'($urandom);
         if (t % 3 == 0) skey = rkey[t % N];
         search("R1 R2 R3 R4 R7 random");
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule